// File: doc/BRIEF.md
# Timer-Edge Square-Wave Tone Pair

This block converts the terminal-count outputs of two counter/timer channels into two square-wave audio sample streams. Every rising edge on a channel's timer output flips that channel's 7-bit amplitude between 0 and 127. Each rising edge also marks the channel as active for the sample window in progress.

A sample-rate tick closes the window. For each channel the block registers a signed 16-bit sample. The sample is the amplitude moved into the upper byte if the channel saw at least one rising edge in the window, and zero otherwise. The sample comes with a one-cycle valid strobe. When a timer stops toggling, its channel falls silent at the next tick instead of holding a DC level.

The timer outputs may be asynchronous to the block clock. They pass through a synchronizer before edge detection. The timers themselves, mixing and filtering are outside this block.

Top module: `edge_tone_pair`

## Requirements
- R1: The two channels are independent: edges on timer input bit 0 affect only sample lane 0, and edges on bit 1 affect only lane 1.
- R2: A rising edge on a channel's timer input flips its 7-bit amplitude by XOR with 0x7F, so the amplitude alternates between 0 and 127. A falling edge changes nothing: it neither flips the amplitude nor marks the channel active.
- R3: A rising edge marks its channel active for the current sample window.
- R4: At a tick, an active channel's sample is its amplitude shifted left by 8 bits, so it is 0x7F00 or 0x0000. An inactive channel's sample is 0x0000. The sample holds its value until the next tick.
- R5: The active mark is cleared by every tick. A window with no rising edge produces 0x0000 at its tick.
- R6: After reset, both amplitudes and both active marks are zero, both samples read 0x0000, and both valid strobes are low.
- R7: Each timer input passes through a two-flop synchronizer, and a rising edge is found by comparison with a registered copy. A level driven just after clock edge k is counted in a window whose tick is first registered at edge k+3, and not in one registered at edge k+2.
- R8: If a rising edge is detected in the same cycle as a tick, the edge counts toward the window that the tick closes, and the sample carries the already-flipped amplitude.
- R9: Each valid strobe is high for exactly the one cycle after a tick cycle and low otherwise.
- R10: Several rising edges in one window each flip the amplitude. The sample uses the amplitude left after all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_i | input | 2 | Timer terminal-count outputs, bit n feeds channel n, may be asynchronous |
| tick_i | input | 1 | Sample-rate tick, one clock wide, synchronous |
| sample_o | output | 2x16 | Signed samples, lane n for channel n |
| valid_o | output | 2 | Per-channel strobe marking a new sample |

## Verification
The hardest case to reach is the one where a detected rising edge and the tick fall in the same clock cycle. That cycle sits behind three registers (two synchronizer flops and the edge-detect copy). The stimulus raises the timer just after a clock edge and asserts the tick exactly two cycles later, so that both meet in the edge-detect cycle. A neighbouring run asserts the tick one cycle earlier, which shows the edge moving into the following window. Amplitude-preserving patterns are also needed to tell an idle window from an active one at level zero: a double edge in one window, and a falling edge followed by two rises.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int LEVEL_W  = 7;
    localparam int SAMPLE_W = 16;
    localparam int SHIFT    = SAMPLE_W - LEVEL_W - 1;

    typedef logic [LEVEL_W-1:0]         level_t;
    typedef logic signed [SAMPLE_W-1:0] sample_t;

    localparam level_t TOGGLE = {LEVEL_W{1'b1}};

    typedef struct packed {
        logic    prev;
        level_t  level;
        logic    active;
        sample_t sample;
        logic    valid;
    } chan_state_t;

    function automatic sample_t to_sample(level_t lvl);
        return sample_t'({lvl, {SHIFT{1'b0}}});
    endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    initial assert (STAGES >= 2) else $error("tone_sync needs at least two stages");

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    timer_i,
    input  logic    tick_i,
    output sample_t sample_o,
    output logic    valid_o
);
    logic        timer_s;
    logic        rise;
    level_t      lvl_now;
    chan_state_t st_d, st_q;

    tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (timer_i),
        .q_o   (timer_s)
    );

    always_comb begin
        st_d      = st_q;
        rise      = timer_s & ~st_q.prev;
        lvl_now   = rise ? (st_q.level ^ TOGGLE) : st_q.level;
        st_d.prev = timer_s;
        st_d.level = lvl_now;
        if (tick_i) begin
            st_d.sample = (st_q.active | rise) ? to_sample(lvl_now) : '0;
            st_d.active = 1'b0;
            st_d.valid  = 1'b1;
        end else begin
            st_d.active = st_q.active | rise;
            st_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign valid_o  = st_q.valid;

    AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rise |=> $stable(st_q.level)); // R2
    AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.level == '0) || (st_q.level == TOGGLE)); // R2
    AST_RISE_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && !tick_i) |=> st_q.active); // R3
    AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !st_q.active && !rise) |=> (sample_o == '0)); // R5
    AST_LOW_BYTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o[SHIFT-1:0] == '0); // R4
    AST_MARK_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !st_q.active); // R5
endmodule

// File: rtl/edge_tone_pair.sv
module edge_tone_pair
    import tone_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_CH-1:0]                timer_i,
    input  logic                             tick_i,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]  sample_o,
    output logic [NUM_CH-1:0]                valid_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        sample_t smp;
        tone_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .timer_i (timer_i[g]),
            .tick_i  (tick_i),
            .sample_o(smp),
            .valid_o (valid_o[g])
        );
        assign sample_o[g] = smp;
    end

    AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (valid_o == {NUM_CH{1'b1}})); // R9
    AST_VALID_ONLY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> (valid_o == '0)); // R9
    AST_SAMPLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(sample_o)); // R4
endmodule

// File: tb/sim_edge_tone_pair.sv
module sim_edge_tone_pair;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        timer = 2'b00;
    logic              tick = 1'b0;
    logic [1:0][15:0]  sample;
    logic [1:0]        valid;
    int                errors = 0;
    int                checks = 0;
    bit                done = 1'b0;

    always #5 clk = ~clk;

    edge_tone_pair u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .timer_i (timer),
        .tick_i  (tick),
        .sample_o(sample),
        .valid_o (valid)
    );

    // {rise ch0, rise ch1, expected lane0, expected lane1}
    localparam logic [33:0] VEC [9] = '{
        {1'b1, 1'b0, 16'h7F00, 16'h0000},
        {1'b1, 1'b1, 16'h0000, 16'h7F00},
        {1'b0, 1'b0, 16'h0000, 16'h0000},
        {1'b0, 1'b1, 16'h0000, 16'h0000},
        {1'b1, 1'b0, 16'h7F00, 16'h0000},
        {1'b0, 1'b0, 16'h0000, 16'h0000},
        {1'b1, 1'b1, 16'h0000, 16'h7F00},
        {1'b0, 1'b1, 16'h0000, 16'h0000},
        {1'b0, 1'b1, 16'h0000, 16'h7F00}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    // tick for one cycle, then check samples and the one-cycle strobe
    task automatic tick_check(string req, logic [15:0] e0, logic [15:0] e1);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk({req, " lane0"}, sample[0], e0);
        chk({req, " lane1"}, sample[1], e1);
        chk("R9 valid high after tick", {14'b0, valid}, 16'h0003);
        @(negedge clk);
        chk("R9 valid low next cycle", {14'b0, valid}, 16'h0000);
        chk("R4 sample held lane0", sample[0], e0);
    endtask

    task automatic pulse(logic [1:0] which);
        @(negedge clk) timer = which;
        settle(4);
        timer = 2'b00;
        settle(4);
    endtask

    initial begin
        settle(3);
        chk("R6 reset lane0", sample[0], 16'h0000);
        chk("R6 reset lane1", sample[1], 16'h0000);
        chk("R6 reset valid", {14'b0, valid}, 16'h0000);
        @(negedge clk) rst_n = 1'b1;
        settle(2);

        // R1 R2 R3 R4 R5: table walk
        for (int i = 0; i < 9; i++) begin
            if (VEC[i][33:32] != 2'b00) pulse({VEC[i][32], VEC[i][33]});
            else settle(4);
            tick_check($sformatf("R1/R4 vector %0d", i), VEC[i][31:16], VEC[i][15:0]);
        end
        // levels now: ch0 = 0x00, ch1 = 0x7F

        // R7: tick registered at edge k+2 misses the rise, next window catches it
        @(negedge clk) timer[0] = 1'b1;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R7 too early lane0", sample[0], 16'h0000);
        settle(3);
        tick_check("R7 next window", 16'h7F00, 16'h0000);   // ch0 = 0x7F

        // R2: falling edge neither activates nor flips
        @(negedge clk) timer[0] = 1'b0;
        settle(4);
        tick_check("R2 fall silent", 16'h0000, 16'h0000);
        pulse(2'b01);                                        // ch0 = 0x00
        tick_check("R2 rise after fall", 16'h0000, 16'h0000);

        // R8: detected rise coincides with tick
        @(negedge clk) timer[0] = 1'b1;                      // after edge k
        settle(2);                                           // after edge k+2
        tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R8 coincident lane0", sample[0], 16'h7F00);     // ch0 = 0x7F
        settle(1);
        @(negedge clk) timer[0] = 1'b0;
        settle(4);
        tick_check("R5 after coincident", 16'h0000, 16'h0000);

        // R10: two rises in one window on ch1 keep 0x7F but mark active
        pulse(2'b10);
        pulse(2'b10);
        tick_check("R10 double rise", 16'h0000, 16'h7F00);

        // R6: reset mid-run clears levels and samples
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R6 mid reset lane1", sample[1], 16'h0000);
        rst_n = 1'b1;
        settle(2);
        pulse(2'b11);
        tick_check("R6 levels cleared", 16'h7F00, 16'h7F00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule